// File: doc/BRIEF.md
# Windowed Horizontal Sync Filter

This block cleans up a horizontal sync pulse train that may carry extra pulses, such as the equalization pulses of an interlaced vertical interval. It measures the spacing of the incoming rising edges in reference-clock cycles. It then predicts where the next edge should fall and accepts only edges that arrive inside a window of plus or minus a programmable number of cycles around that prediction. Edges outside the window are thrown away.

Lock has hysteresis. A programmable count of consecutive in-window edges is needed to declare lock. Once locked, a programmable count of consecutive empty windows is needed to drop it. While locked, the measured spacing is frozen. A clean pulse of fixed width is regenerated at each predicted edge, and it is still produced when the raw edge is missing. While unlocked, the regenerated output simply follows the raw input.

Two select inputs let the downstream line-processing logic and the downstream PLL each take either the raw input or the regenerated pulse. The recommended settings are regenerated for line processing and raw for the PLL.

The controller has four named states:
- `ST_SEEK` waits for any edge and moves to `ST_MEASURE` on it (transition *first edge*).
- `ST_MEASURE` takes the next edge as the first spacing sample and moves to `ST_ACQ` (transition *spacing taken*).
- `ST_ACQ` moves to `ST_LOCK` when the valid count reaches the lock threshold (transition *lock reached*). It returns to `ST_SEEK` when a window expires empty (transition *acquire miss*).
- `ST_LOCK` returns to `ST_SEEK` when the consecutive-miss count reaches the unlock threshold (transition *lock lost*).

Top module: `hsync_sync_filter`

## Requirements
- R1: After reset `locked` is 0. While `locked` is 0, `hsync_regen` equals `sync_raw` in the same cycle, with no register in the path.
- R2: The first rising edge after `ST_SEEK` sets the reference. The second edge gives the first spacing. Each later edge that lands inside the window counts as valid. `locked` rises just after the clock edge at which the valid count reaches `lock_thr`, which is at edge number `lock_thr`+2. A `lock_thr` of 0 behaves as 1.
- R3: Before lock, a window that expires with no edge clears the valid count and returns the filter to `ST_SEEK`. A full new acquisition is then needed.
- R4: An edge is accepted when its spacing from the previous reference lies within plus or minus `win_half` cycles of the expected spacing, boundaries included. Edges that arrive earlier are ignored. Before lock, the expected spacing is re-measured on each accepted edge.
- R5: While locked, the expected spacing stays fixed. Each window that expires empty counts one miss, and the next prediction is then taken from the predicted time. An accepted edge clears the miss count. `locked` falls at the expiry where the consecutive-miss count reaches `unlock_thr`. An `unlock_thr` of 0 behaves as 1.
- R6: While locked, `hsync_regen` is high for exactly PULSE_W cycles per line. The pulse starts in the cycle after the predicted edge time, or after an accepted edge that arrives earlier than predicted. It is produced even when the raw edge is missing.
- R7: While locked, a raw pulse outside the window does not appear on `hsync_regen` and does not change `locked`.
- R8: `proc_sync` equals `hsync_regen` when `proc_sel_filt` is 1 and equals `sync_raw` when it is 0. `pll_sync` makes the same choice under `pll_sel_filt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_raw | input | 1 | Raw horizontal sync (active high) |
| lock_thr | input | 8 | Valid edges needed for lock |
| unlock_thr | input | 8 | Consecutive missing edges needed to drop lock |
| win_half | input | 8 | Window half-width in reference cycles |
| proc_sel_filt | input | 1 | 1: line processing takes the regenerated sync |
| pll_sel_filt | input | 1 | 1: PLL takes the regenerated sync |
| hsync_regen | output | 1 | Regenerated sync |
| locked | output | 1 | Filter locked |
| proc_sync | output | 1 | Sync for line processing |
| pll_sync | output | 1 | Sync for the PLL |

## Verification
The bench keeps the default parameters: PULSE_W of 4, a 12-bit cycle counter and 8-bit thresholds. It drives a 40-cycle line with `win_half` set to 4. This keeps each scenario to a few hundred cycles, while the window edges still sit at plus or minus 4 cycles, where accept and reject can be told apart by one cycle of offset. Setting the thresholds as low as 0, 1 and 2 brings lock entry, single-miss unlock and the behaviour of a zero threshold within reach. Setting them to 5 lets the miss count be seen both resetting on an accepted edge and unlocking exactly at its limit.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
    typedef enum logic [1:0] {
        ST_SEEK    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_ACQ     = 2'd2,
        ST_LOCK    = 2'd3
    } hsf_state_e;
endpackage

// File: rtl/hsf_window.sv
module hsf_window
    import hsf_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  hsf_state_e       st,
    input  logic [WIN_W-1:0] win_half,
    output logic             accept,
    output logic             expire,
    output logic             regen_start
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             sync_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic [CNT_W:0]   cnt_x, per_x, win_x, lo, hi;
    logic             rise, tracking, in_win;

    assign rise     = sync_in & ~sync_q;
    assign tracking = (st == ST_ACQ) || (st == ST_LOCK);
    assign cnt_x    = {1'b0, cnt};
    assign per_x    = {1'b0, period};
    assign win_x    = (CNT_W+1)'(win_half);
    assign hi       = per_x + win_x;
    assign lo       = (per_x > win_x) ? (per_x - win_x) : '0;
    assign in_win   = (cnt_x >= lo) && (cnt_x <= hi);

    assign accept   = rise & (tracking ? in_win : 1'b1);
    assign expire   = tracking & ~accept & ((cnt_x >= hi) | (cnt == CNT_MAX));

    // pulse at predicted time, or earlier on an accepted early edge
    assign regen_start = (st == ST_LOCK) &
                         ((accept & (cnt <= period)) | (cnt == period));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            cnt    <= '0;
            period <= '0;
        end else begin
            sync_q <= sync_in;
            if (accept) begin
                cnt <= '0;
                if (st == ST_MEASURE || st == ST_ACQ)
                    period <= cnt;
            end else if (expire) begin
                // re-reference to the predicted edge time
                cnt <= CNT_W'(win_half);
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + CNT_ONE;
            end
        end
    end

    AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK && $past(st) == ST_LOCK) |-> $stable(period)); // R5
endmodule

// File: rtl/hsf_fsm.sv
module hsf_fsm
    import hsf_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             expire,
    input  logic [THR_W-1:0] lock_thr,
    input  logic [THR_W-1:0] unlock_thr,
    output hsf_state_e       st,
    output logic             locked
);
    localparam logic [THR_W:0] ONE = (THR_W+1)'(1);

    hsf_state_e     st_nx;
    logic [THR_W:0] vcnt, vcnt_nx, vcnt_inc;
    logic [THR_W:0] mcnt, mcnt_nx, mcnt_inc;

    assign vcnt_inc = vcnt + ONE;
    assign mcnt_inc = mcnt + ONE;
    assign locked   = (st == ST_LOCK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_SEEK;
            vcnt <= '0;
            mcnt <= '0;
        end else begin
            st   <= st_nx;
            vcnt <= vcnt_nx;
            mcnt <= mcnt_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        vcnt_nx = vcnt;
        mcnt_nx = mcnt;
        unique case (st)
            ST_SEEK: begin
                if (accept) st_nx = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (accept) begin
                    st_nx   = ST_ACQ;
                    vcnt_nx = '0;
                end
            end
            ST_ACQ: begin
                if (accept) begin
                    if (vcnt_inc >= {1'b0, lock_thr}) begin
                        st_nx   = ST_LOCK;
                        mcnt_nx = '0;
                    end else begin
                        vcnt_nx = vcnt_inc;
                    end
                end else if (expire) begin
                    st_nx   = ST_SEEK;
                    vcnt_nx = '0;
                end
            end
            ST_LOCK: begin
                if (accept) begin
                    mcnt_nx = '0;
                end else if (expire) begin
                    if (mcnt_inc >= {1'b0, unlock_thr}) begin
                        st_nx   = ST_SEEK;
                        mcnt_nx = '0;
                    end else begin
                        mcnt_nx = mcnt_inc;
                    end
                end
            end
            default: st_nx = ST_SEEK;
        endcase
    end

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(st) == ST_ACQ && $past(accept))); // R2
    AST_ACQ_MISS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACQ && expire) |=> (st == ST_SEEK && vcnt == '0)); // R3
    AST_UNLOCK_TO_SEEK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (st == ST_SEEK && $past(expire))); // R5
    AST_MISS_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (mcnt < {1'b0, unlock_thr} || unlock_thr == '0)); // R5
endmodule

// File: rtl/hsf_pulse.sv
module hsf_pulse #(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse_on
);
    localparam int PCW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
    localparam logic [PCW-1:0] PC_ONE = PCW'(1);

    logic [PCW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_on <= 1'b0;
            pcnt     <= '0;
        end else if (start) begin
            pulse_on <= 1'b1;
            pcnt     <= PCW'(PULSE_W - 1);
        end else if (pcnt != '0) begin
            pcnt <= pcnt - PC_ONE;
        end else begin
            pulse_on <= 1'b0;
        end
    end

    AST_PULSE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_on) |-> $past(start)); // R6
endmodule

// File: rtl/hsync_sync_filter.sv
module hsync_sync_filter
    import hsf_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int THR_W   = 8,
    parameter int WIN_W   = 8,
    parameter int PULSE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_raw,
    input  logic [THR_W-1:0] lock_thr,
    input  logic [THR_W-1:0] unlock_thr,
    input  logic [WIN_W-1:0] win_half,
    input  logic             proc_sel_filt,
    input  logic             pll_sel_filt,
    output logic             hsync_regen,
    output logic             locked,
    output logic             proc_sync,
    output logic             pll_sync
);
    hsf_state_e st;
    logic       accept, expire, regen_start, pulse_on;

    hsf_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_in     (sync_raw),
        .st          (st),
        .win_half    (win_half),
        .accept      (accept),
        .expire      (expire),
        .regen_start (regen_start)
    );

    hsf_fsm #(.THR_W(THR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .expire     (expire),
        .lock_thr   (lock_thr),
        .unlock_thr (unlock_thr),
        .st         (st),
        .locked     (locked)
    );

    hsf_pulse #(.PULSE_W(PULSE_W)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (regen_start),
        .pulse_on (pulse_on)
    );

    assign hsync_regen = locked ? pulse_on : sync_raw;
    assign proc_sync   = proc_sel_filt ? hsync_regen : sync_raw;
    assign pll_sync    = pll_sel_filt  ? hsync_regen : sync_raw;
endmodule

// File: tb/tb_hsync_sync_filter.sv
module tb_hsync_sync_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_raw = 1'b0;
    logic [7:0] lock_thr = 8'd5;
    logic [7:0] unlock_thr = 8'd3;
    logic [7:0] win_half = 8'd4;
    logic       proc_sel_filt = 1'b1;
    logic       pll_sel_filt = 1'b0;
    logic       hsync_regen, locked, proc_sync, pll_sync;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    hsync_sync_filter dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sync_raw      (sync_raw),
        .lock_thr      (lock_thr),
        .unlock_thr    (unlock_thr),
        .win_half      (win_half),
        .proc_sel_filt (proc_sel_filt),
        .pll_sel_filt  (pll_sel_filt),
        .hsync_regen   (hsync_regen),
        .locked        (locked),
        .proc_sync     (proc_sync),
        .pll_sync      (pll_sync)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(int lthr, int uthr);
        @(negedge clk);
        rst_n = 1'b0;
        sync_raw = 1'b0;
        lock_thr = 8'(lthr);
        unlock_thr = 8'(uthr);
        win_half = 8'd4;
        proc_sel_filt = 1'b1;
        pll_sel_filt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one raw line: 3-cycle high pulse, next rise 'sp' cycles later
    task automatic send_line(int sp);
        sync_raw = 1'b1;
        repeat (3) @(negedge clk);
        sync_raw = 1'b0;
        repeat (sp - 3) @(negedge clk);
    endtask

    task automatic gap(int n);
        sync_raw = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic lock_up(int lines);
        for (int i = 0; i < lines; i++) send_line(40);
    endtask

    task automatic t_reset;
        do_reset(5, 3);
        chk("R1", "locked after reset", int'(locked), 0);
        chk("R1", "regen low with raw low", int'(hsync_regen), 0);
        sync_raw = 1'b1;
        #1;
        chk("R1", "regen follows raw high", int'(hsync_regen), 1);
        @(negedge clk);
        sync_raw = 1'b0;
        #1;
        chk("R1", "regen follows raw low", int'(hsync_regen), 0);
    endtask

    task automatic t_lock_jitter;
        int sp[7] = '{40, 40, 43, 39, 40, 44, 40};
        do_reset(5, 3);
        for (int i = 0; i < 6; i++) send_line(sp[i]);
        chk("R2", "not locked after 6 edges", int'(locked), 0);
        send_line(sp[6]);
        chk("R2", "locked after 7 edges (thr 5)", int'(locked), 1);
    endtask

    task automatic t_lock_zero;
        do_reset(0, 3);
        lock_up(2);
        chk("R2", "thr 0: not locked after 2 edges", int'(locked), 0);
        send_line(40);
        chk("R2", "thr 0: locked after 3 edges", int'(locked), 1);
    endtask

    task automatic t_acq_miss;
        do_reset(5, 3);
        lock_up(4);
        send_line(80);
        chk("R3", "no lock across acquire miss", int'(locked), 0);
        lock_up(6);
        chk("R3", "valid count restarted, 6 edges", int'(locked), 0);
        send_line(40);
        chk("R3", "locked after full reacquire", int'(locked), 1);
    endtask

    task automatic t_window;
        do_reset(2, 1);
        lock_up(4);
        chk("R2", "thr 2: locked after 4 edges", int'(locked), 1);
        send_line(44);
        send_line(40);
        chk("R4", "late edge at +4 accepted", int'(locked), 1);
        send_line(36);
        send_line(40);
        chk("R4", "early edge at -4 accepted", int'(locked), 1);
        send_line(45);
        chk("R4", "late edge at +5 rejected", int'(locked), 0);
        sync_raw = 1'b1;
        #1;
        chk("R1", "regen follows raw after unlock", int'(hsync_regen), 1);
        // early reject
        do_reset(2, 1);
        lock_up(4);
        send_line(35);
        sync_raw = 1'b1;
        @(posedge clk);
        #1;
        chk("R7", "early edge -5 not on regen", int'(hsync_regen), 0);
        @(negedge clk);
        repeat (2) @(negedge clk);
        gap(9);
        chk("R4", "early edge at -5 ignored, miss", int'(locked), 0);
    endtask

    task automatic t_equalize;
        do_reset(2, 3);
        lock_up(4);
        sync_raw = 1'b1;
        repeat (3) @(negedge clk);
        sync_raw = 1'b0;
        repeat (17) @(negedge clk);
        sync_raw = 1'b1;
        @(posedge clk);
        #1;
        chk("R7", "mid-line pulse absent on regen", int'(hsync_regen), 0);
        chk("R8", "pll_sync raw when sel 0", int'(pll_sync), 1);
        chk("R8", "proc_sync filtered when sel 1", int'(proc_sync), 0);
        @(negedge clk);
        repeat (2) @(negedge clk);
        sync_raw = 1'b0;
        repeat (17) @(negedge clk);
        lock_up(3);
        chk("R7", "lock kept after mid-line pulse", int'(locked), 1);
    endtask

    task automatic t_flywheel;
        int n_reg = 0;
        int n_pll = 0;
        int n_proc = 0;
        int first = -1;
        do_reset(2, 5);
        proc_sel_filt = 1'b0;
        pll_sel_filt = 1'b1;
        lock_up(4);
        for (int i = 0; i < 120; i++) begin
            if (hsync_regen) begin
                n_reg++;
                if (first < 0) first = i;
            end
            if (pll_sync) n_pll++;
            if (proc_sync) n_proc++;
            @(negedge clk);
        end
        chk("R6", "regen high cycles over 3 missing lines", n_reg, 12);
        chk("R6", "regen start offset", first, 1);
        chk("R8", "pll_sync filtered high cycles", n_pll, 12);
        chk("R8", "proc_sync raw high cycles", n_proc, 0);
        chk("R5", "locked after 3 misses (thr 5)", int'(locked), 1);
        send_line(40);
        gap(150);
        chk("R5", "locked after 4 misses, count was cleared", int'(locked), 1);
        gap(30);
        chk("R5", "unlocked at 5th miss", int'(locked), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lock_jitter();
        t_lock_zero();
        t_acq_miss();
        t_window();
        t_equalize();
        t_flywheel();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule